// File: doc/BRIEF.md
# Three-Point Multiplier-Free Hartley Transform Engine

This block computes a 3-point discrete Hartley transform of three signed samples without using a single multiplier. It uses distributed arithmetic in offset-binary form. A pulse on `start` captures the three two's-complement samples into shift registers. The samples then leave those registers together, one bit per cycle and least significant bit first. Each output has its own lane: a four-word constant table and a shift-accumulate register. The table is indexed by the XOR of sample 0 and sample 2, and by the XOR of sample 1 and sample 2. The bit of sample 2 chooses whether the table word is added or subtracted. During the sign-bit cycle that choice is inverted.

After the last bit, a fixed offset term is added to each accumulator, the value is rounded to the output width, and `done` pulses for one cycle. The kernel constants are fixed-point parameters with `COEF_FRAC` fractional bits. The default values represent 1, cas(2π/3) and cas(4π/3). Because the offset-binary form exploits symmetry, each table needs only four words instead of eight.

The intended use is as the one-dimensional stage of a small image transform. A controller issues one `start` per sample triple and collects the three results when `done` pulses.

Top module: `dht3_da_top`

## Requirements
- R1: After reset, `done` is 0 and `yOut0`, `yOut1`, `yOut2` are all 0.
- R2: Each output equals floor((S_k + 2^(COEF_FRAC-1)) / 2^COEF_FRAC), taken to OUT_W bits. Here S_k = sum over n of h[k][n]·x_n. With the defaults (COEF_FRAC=12), h[k][n] = 4096 when k=0 or n=0, 1499 when (k·n) mod 3 = 1, and −5595 when (k·n) mod 3 = 2.
- R3: `done` is a single-cycle pulse. It rises right after the rising edge that comes DATA_W+1 edges after the edge that accepted `start`, and it stays 0 between those two edges.
- R4: The samples are captured only on the edge that accepts `start`; later changes on `xIn0..2` have no effect on that transform's results.
- R5: A `start` that arrives while a transform is running is ignored. It neither restarts the transform, nor changes its results, nor produces an extra `done`.
- R6: The outputs hold their values from one `done` pulse until the next.
- R7: The full two's-complement range is handled, including the most negative sample value, with the sign bit weighted negatively.
- R8: Output index k corresponds to kernel row k. An impulse on sample n therefore yields column n of the kernel, rounded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transform; accepted only when idle |
| xIn0 | input | DATA_W | Sample 0, two's complement |
| xIn1 | input | DATA_W | Sample 1, two's complement |
| xIn2 | input | DATA_W | Sample 2, two's complement |
| yOut0 | output | OUT_W | Result for kernel row 0 |
| yOut1 | output | OUT_W | Result for kernel row 1 |
| yOut2 | output | OUT_W | Result for kernel row 2 |
| done | output | 1 | One-cycle pulse when results update |

## Verification
The assertions count cycles from an accepted `start` on their own counter. That counter assumes `start` is sampled only at rising edges and that the block's idle state matches the counter's view after reset. The stimulus drives `start` and the samples on falling edges. It holds `start` for exactly one cycle, except where it deliberately pulses `start` in the middle of a run. Samples are drawn from the whole signed range, with directed extremes added, so no value falls outside what the output width can hold.

// File: rtl/dht3_pkg.sv
`timescale 1ns/1ps
package dht3_pkg;

  typedef struct packed {
    logic load;      // capture samples, clear accumulators
    logic step;      // consume one bit from every shift register
    logic signStep;  // current bit is the sign bit
    logic finish;    // add offset, round, publish results
  } dht3_strobe_t;

  function automatic int kernelCoef(input int k, input int n,
                                    input int one, input int casPos, input int casNeg);
    if (k == 0 || n == 0) return one;
    if (((k * n) % 3) == 1) return casPos;
    return casNeg;
  endfunction

endpackage

// File: rtl/dht3_ctrl.sv
`timescale 1ns/1ps
module dht3_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  output dht3_pkg::dht3_strobe_t strobe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] SIGN_CNT = CNT_W'(DATA_W - 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctrl_state_e;

  ctrl_state_e state;
  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    strobe.load     = (state == ST_IDLE) && start;
    strobe.step     = (state == ST_RUN) && (bitCnt != LAST_CNT);
    strobe.signStep = (state == ST_RUN) && (bitCnt == SIGN_CNT);
    strobe.finish   = (state == ST_RUN) && (bitCnt == LAST_CNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      if (strobe.load) begin
        state  <= ST_RUN;
        bitCnt <= '0;
      end else if (strobe.step) begin
        bitCnt <= bitCnt + 1'b1;
      end else if (strobe.finish) begin
        state <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/dht3_lane.sv
`timescale 1ns/1ps
module dht3_lane #(
  parameter int DATA_W    = 8,
  parameter int COEF_FRAC = 12,
  parameter int OUT_W     = 10,
  parameter int H0        = 4096,
  parameter int H1        = 4096,
  parameter int H2        = 4096
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dht3_pkg::dht3_strobe_t  strobe,
  input  logic [2:0]              bits,
  output logic signed [OUT_W-1:0] y
);
  // Table words are stored in units of 2^-(COEF_FRAC+1), so the half-sums are exact.
  localparam int ROM_W = COEF_FRAC + 4;
  localparam int ACC_W = ROM_W + DATA_W + 1;
  localparam logic signed [ROM_W-1:0] ROM_PP = ROM_W'( H0 + H1 + H2);
  localparam logic signed [ROM_W-1:0] ROM_PN = ROM_W'( H0 - H1 + H2);
  localparam logic signed [ROM_W-1:0] ROM_NP = ROM_W'(-H0 + H1 + H2);
  localparam logic signed [ROM_W-1:0] ROM_NN = ROM_W'(-H0 - H1 + H2);
  localparam logic signed [ACC_W-1:0] OFFSET = ACC_W'(-(H0 + H1 + H2));
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< COEF_FRAC;

  logic [1:0] romAddr;
  logic signed [ROM_W-1:0] romWord;
  logic signed [ACC_W-1:0] wordExt, term, acc, withOffset, rounded;
  logic addSel;

  assign romAddr = {bits[0] ^ bits[2], bits[1] ^ bits[2]};

  always_comb begin
    unique case (romAddr)
      2'b00:   romWord = ROM_PP;
      2'b01:   romWord = ROM_PN;
      2'b10:   romWord = ROM_NP;
      default: romWord = ROM_NN;
    endcase
  end

  // The sign-bit cycle has negative weight, so its add/subtract choice flips.
  assign addSel     = bits[2] ^ strobe.signStep;
  assign wordExt    = ACC_W'(romWord);
  assign term       = addSel ? wordExt : -wordExt;
  assign withOffset = acc + OFFSET;
  assign rounded    = (withOffset + HALF_LSB) >>> (COEF_FRAC + 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strobe.load) begin
      acc <= '0;
    end else if (strobe.step) begin
      acc <= (acc >>> 1) + (term <<< (DATA_W - 1));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      y <= '0;
    end else if (strobe.finish) begin
      y <= OUT_W'(rounded);
    end
  end
endmodule

// File: rtl/dht3_datapath.sv
`timescale 1ns/1ps
module dht3_datapath #(
  parameter int DATA_W    = 8,
  parameter int COEF_FRAC = 12,
  parameter int OUT_W     = 10,
  parameter int COEF_ONE  = 4096,
  parameter int COEF_POS  = 1499,
  parameter int COEF_NEG  = -5595
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dht3_pkg::dht3_strobe_t  strobe,
  input  logic [DATA_W-1:0]       xIn0,
  input  logic [DATA_W-1:0]       xIn1,
  input  logic [DATA_W-1:0]       xIn2,
  output logic signed [OUT_W-1:0] yOut0,
  output logic signed [OUT_W-1:0] yOut1,
  output logic signed [OUT_W-1:0] yOut2,
  output logic                    done
);
  localparam int POINTS = 3;

  logic [DATA_W-1:0] sampleIn [POINTS];
  logic [DATA_W-1:0] shiftReg [POINTS];
  logic [POINTS-1:0] bitSlice;
  logic signed [OUT_W-1:0] laneOut [POINTS];

  assign sampleIn[0] = xIn0;
  assign sampleIn[1] = xIn1;
  assign sampleIn[2] = xIn2;

  for (genvar n = 0; n < POINTS; n++) begin : g_piso
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shiftReg[n] <= '0;
      end else if (strobe.load) begin
        shiftReg[n] <= sampleIn[n];
      end else if (strobe.step) begin
        shiftReg[n] <= shiftReg[n] >> 1;
      end
    end
    assign bitSlice[n] = shiftReg[n][0];
  end

  for (genvar k = 0; k < POINTS; k++) begin : g_lane
    dht3_lane #(
      .DATA_W   (DATA_W),
      .COEF_FRAC(COEF_FRAC),
      .OUT_W    (OUT_W),
      .H0       (dht3_pkg::kernelCoef(k, 0, COEF_ONE, COEF_POS, COEF_NEG)),
      .H1       (dht3_pkg::kernelCoef(k, 1, COEF_ONE, COEF_POS, COEF_NEG)),
      .H2       (dht3_pkg::kernelCoef(k, 2, COEF_ONE, COEF_POS, COEF_NEG))
    ) lane_i (
      .clk   (clk),
      .rstN  (rstN),
      .strobe(strobe),
      .bits  (bitSlice),
      .y     (laneOut[k])
    );
  end

  assign yOut0 = laneOut[0];
  assign yOut1 = laneOut[1];
  assign yOut2 = laneOut[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= strobe.finish;
  end
endmodule

// File: rtl/dht3_da_top.sv
`timescale 1ns/1ps
module dht3_da_top #(
  parameter int DATA_W    = 8,
  parameter int COEF_FRAC = 12,
  parameter int COEF_ONE  = 4096,
  parameter int COEF_POS  = 1499,
  parameter int COEF_NEG  = -5595,
  localparam int OUT_W    = DATA_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [DATA_W-1:0]       xIn0,
  input  logic [DATA_W-1:0]       xIn1,
  input  logic [DATA_W-1:0]       xIn2,
  output logic signed [OUT_W-1:0] yOut0,
  output logic signed [OUT_W-1:0] yOut1,
  output logic signed [OUT_W-1:0] yOut2,
  output logic                    done
);
  dht3_pkg::dht3_strobe_t strobeS;

  dht3_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strobe(strobeS)
  );

  dht3_datapath #(
    .DATA_W   (DATA_W),
    .COEF_FRAC(COEF_FRAC),
    .OUT_W    (OUT_W),
    .COEF_ONE (COEF_ONE),
    .COEF_POS (COEF_POS),
    .COEF_NEG (COEF_NEG)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobeS),
    .xIn0  (xIn0),
    .xIn1  (xIn1),
    .xIn2  (xIn2),
    .yOut0 (yOut0),
    .yOut1 (yOut1),
    .yOut2 (yOut2),
    .done  (done)
  );
endmodule

// File: rtl/dht3_da_chk.sv
`timescale 1ns/1ps
module dht3_da_chk #(
  parameter int DATA_W = 8,
  parameter int OUT_W  = 10
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    start,
  input logic                    done,
  input logic signed [OUT_W-1:0] y0,
  input logic signed [OUT_W-1:0] y1,
  input logic signed [OUT_W-1:0] y2,
  input dht3_pkg::dht3_strobe_t  strobe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);

  logic cBusy;
  logic [CNT_W-1:0] cCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cBusy <= 1'b0;
      cCnt  <= '0;
    end else if (!cBusy) begin
      if (start) begin
        cBusy <= 1'b1;
        cCnt  <= '0;
      end
    end else if (cCnt == LAST_CNT) begin
      cBusy <= 1'b0;
    end else begin
      cCnt <= cCnt + 1'b1;
    end
  end

  // R3: done lasts exactly one cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: done appears only at the end of the counted window
  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(cBusy) && $past(cCnt) == LAST_CNT));

  // R5: no done while a transform is running
  p_quiet_run_r5: assert property (@(posedge clk) disable iff (!rstN)
    cBusy |-> !done);

  // R5: a capture happens only when idle
  p_load_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !cBusy);

  // R5: control strobes never overlap
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.step, strobe.finish}));

  // R6: results change only together with done
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(y0) || !$stable(y1) || !$stable(y2)) |-> done);
endmodule

bind dht3_da_top dht3_da_chk #(.DATA_W(DATA_W), .OUT_W(OUT_W)) chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .done  (done),
  .y0    (yOut0),
  .y1    (yOut1),
  .y2    (yOut2),
  .strobe(strobeS)
);

// File: tb/dht3_da_top_tb_top.sv
`timescale 1ns/1ps
module dht3_da_top_tb_top;
  localparam int DW = 8;
  localparam int OW = DW + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] x0 = '0, x1 = '0, x2 = '0;
  logic signed [OW-1:0] y0, y1, y2;
  logic done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dht3_da_top dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .xIn0(x0), .xIn1(x1), .xIn2(x2),
    .yOut0(y0), .yOut1(y1), .yOut2(y2), .done(done)
  );

  function automatic longint coef(int k, int n);
    if (k == 0 || n == 0) return 4096;
    return (((k * n) % 3) == 1) ? 1499 : -5595;
  endfunction

  function automatic logic signed [OW-1:0] expY(int k, int a, int b, int c);
    longint s;
    s = coef(k, 0) * a + coef(k, 1) * b + coef(k, 2) * c;
    return OW'((s + 2048) >>> 12);
  endfunction

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // One transform; midStart pulses start during the run (R5).
  task automatic runOne(string tag, int a, int b, int c, bit midStart);
    logic signed [OW-1:0] e0, e1, e2;
    e0 = expY(0, a, b, c);
    e1 = expY(1, a, b, c);
    e2 = expY(2, a, b, c);
    @(negedge clk);
    x0 = DW'(a); x1 = DW'(b); x2 = DW'(c); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    x0 = DW'($urandom); x1 = DW'($urandom); x2 = DW'($urandom); // R4
    for (int i = 1; i <= DW; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (midStart && i == 3) begin
        start = 1'b1;
        x0 = DW'($urandom); x1 = DW'($urandom); x2 = DW'($urandom);
      end else begin
        start = 1'b0;
      end
    end
    check({tag, " R3 done low before end"}, done, 0);
    @(posedge clk);
    @(negedge clk);
    check({tag, " R3 done high"}, done, 1);
    check({tag, " R2 y0"}, y0, e0);
    check({tag, " R2 y1"}, y1, e1);
    check({tag, " R2 y2"}, y2, e2);
    @(negedge clk);
    check({tag, " R3 done pulse ends"}, done, 0);
    if (midStart) begin
      bit extra = 1'b0;
      for (int i = 0; i < DW + 3; i++) begin
        @(negedge clk);
        if (done) extra = 1'b1;
      end
      check({tag, " R5 no extra done"}, extra, 0);
      check({tag, " R5 y0 kept"}, y0, e0);
      check({tag, " R6 y1 held"}, y1, e1);
      check({tag, " R6 y2 held"}, y2, e2);
    end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check("R1 done after reset", done, 0);
    check("R1 y0 after reset", y0, 0);
    check("R1 y1 after reset", y1, 0);
    check("R1 y2 after reset", y2, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 done idle", done, 0);

    runOne("zeros", 0, 0, 0, 1'b0);
    runOne("R8 impulse0", 100, 0, 0, 1'b0);
    runOne("R8 impulse1", 0, 100, 0, 1'b0);
    runOne("R8 impulse2", 0, 0, 100, 1'b0);
    runOne("R7 all max", 127, 127, 127, 1'b0);
    runOne("R7 all min", -128, -128, -128, 1'b0);
    runOne("R7 mixed", -128, 127, -128, 1'b0);
    runOne("R7 mixed2", 127, -128, 127, 1'b0);
    runOne("R7 minus one", -1, -1, -1, 1'b0);
    runOne("R5 mid start", 57, -33, 90, 1'b1);
    runOne("R6 idle gap", -77, 12, 5, 1'b1);

    for (int t = 0; t < 60; t++) begin
      int a, b, c;
      a = int'($signed(DW'($urandom)));
      b = int'($signed(DW'($urandom)));
      c = int'($signed(DW'($urandom)));
      runOne("R2 random", a, b, c, (t % 7) == 0);
    end

    repeat (3) @(negedge clk);
    summary();
  end
endmodule